// File: doc/BRIEF.md
# RGB-to-YUV Output Color Matrix

This block converts a stream of 8-bit-per-lane RGB pixels into YUV at the output of a display compositor. Each output lane comes from one row of a programmable 3x4 matrix. A row holds three signed multipliers, applied to R, G and B, and one signed additive constant. The sum is floored to an integer, limited to the pixel range and sent out two clock cycles after the pixel entered.

A small register write port loads the twelve matrix entries and a conversion-enable bit. After reset the matrix holds limited-range standard-definition coefficients, and conversion is off, so pixels pass through unchanged. The usual sequence is to set the enable bit and then write the twelve entries in index order while pixels keep flowing. A pixel is always processed with the settings that were in place when it entered the block.

Top module: `pix_matrix_csc`

## Requirements
- R1: After reset, out_valid is 0, out_yuv is 0 and conversion is disabled. The entries at index 0 to 11 hold 0x107, 0x204, 0x064, 0x108, 0x3F69, 0x3ED6, 0x1C1, 0x808, 0x1C1, 0x3E88, 0x3FB8 and 0x808.
- R2: While conversion is disabled, each output pixel equals its input pixel bit for bit.
- R3: While conversion is enabled, output lane k (k=0 is Y in bits 23:16, k=1 is U in bits 15:8, k=2 is V in bits 7:0) equals floor((R*c[4k] + G*c[4k+1] + B*c[4k+2])/1024 + c[4k+3]/16). Every entry c is a 14-bit two's-complement value. R is input bits 23:16, G is bits 15:8 and B is bits 7:0.
- R4: A converted lane result below 0 is output as 0, and a result above 255 is output as 255.
- R5: out_valid is high in exactly those cycles that follow by two clock cycles a cycle in which in_valid was high, and in no other cycle.
- R6: A write to address i, for i from 0 to 11, replaces entry c[i]. Its row is i/4 (0 is Y, 1 is U, 2 is V) and its tap is i%4 (R, G, B, then the constant). A write to address 12 sets the conversion enable from cfg_wdata bit 0.
- R7: Writes to addresses 13, 14 and 15 change neither the matrix nor the enable bit.
- R8: A pixel accepted in the same cycle as a register write is processed with the settings in place before that write. Pixels accepted in later cycles use the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_rgb | input | 24 | Input pixel: R in bits 23:16, G in bits 15:8, B in bits 7:0 |
| out_valid | output | 1 | Output pixel present this cycle |
| out_yuv | output | 24 | Output pixel: Y or R in bits 23:16, U or G in bits 15:8, V or B in bits 7:0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index: 0 to 11 select matrix entries, 12 selects the enable |
| cfg_wdata | input | 14 | Write data; bit 0 is the enable when the address is 12 |

## Verification
The case that needs care is a register write landing in the same cycle as an accepted pixel: the pixel must keep the old entry or the old mode, and its successor must use the new one. The bench provokes this by loading all twelve entries, and by turning the enable on and off, with a new pixel offered in every write cycle. Its model computes each pixel's expected value from the settings before the write and only then applies the write. A pixel that picked up the new value, or a later pixel that kept the stale one, shows up as a lane mismatch at the output.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
  localparam int CSC_ROWS = 3;
  localparam int CSC_TAPS = 4;

  typedef enum logic [1:0] {
    TAP_RED   = 2'd0,
    TAP_GREEN = 2'd1,
    TAP_BLUE  = 2'd2,
    TAP_CONST = 2'd3
  } csc_tap_e;

  // Limited-range SD matrix: multipliers have 10 fraction bits, constants 4.
  function automatic logic [15:0] csc_reset_coef(input int idx);
    case (idx)
      0:  return 16'h0107;
      1:  return 16'h0204;
      2:  return 16'h0064;
      3:  return 16'h0108;
      4:  return 16'h3F69;
      5:  return 16'h3ED6;
      6:  return 16'h01C1;
      7:  return 16'h0808;
      8:  return 16'h01C1;
      9:  return 16'h3E88;
      10: return 16'h3FB8;
      11: return 16'h0808;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
`timescale 1ns/1ps
module csc_coef_bank #(
  parameter int ROWS   = 3,
  parameter int TAPS   = 4,
  parameter int COEF_W = 14,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [COEF_W-1:0]             cfg_wdata,
  output logic [ROWS*TAPS*COEF_W-1:0]   coef_o,
  output logic                          conv_en_o
);
  localparam int NUM = ROWS * TAPS;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM);

  logic [COEF_W-1:0] coef_q [NUM];
  logic              conv_en_q;
  logic              coef_hit;
  logic              ctrl_hit;
  logic              dead_hit;

  // decoded write events, also used by the assertions below
  assign coef_hit = cfg_we && (cfg_addr <  CTRL_ADDR);
  assign ctrl_hit = cfg_we && (cfg_addr == CTRL_ADDR);
  assign dead_hit = cfg_we && (cfg_addr >  CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM; k++) begin
        coef_q[k] <= COEF_W'(csc_pkg::csc_reset_coef(k));
      end
      conv_en_q <= 1'b0;
    end else begin
      if (coef_hit) coef_q[cfg_addr] <= cfg_wdata;
      if (ctrl_hit) conv_en_q <= cfg_wdata[0];
    end
  end

  genvar gi;
  for (gi = 0; gi < NUM; gi++) begin : g_flat
    assign coef_o[gi*COEF_W +: COEF_W] = coef_q[gi];
  end
  assign conv_en_o = conv_en_q;

  AST_ENTRY_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    coef_hit |=> coef_o[int'($past(cfg_addr))*COEF_W +: COEF_W] == $past(cfg_wdata)); // R6
  AST_ENABLE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> conv_en_o == $past(cfg_wdata[0])); // R6
  AST_DEAD_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    dead_hit |=> ($stable(coef_o) && $stable(conv_en_o))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(coef_o) && $stable(conv_en_o))); // R7
endmodule

// File: rtl/csc_row.sv
`timescale 1ns/1ps
module csc_row #(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 14,
  parameter int TAPS     = 4,
  parameter int MUL_FRAC = 10,
  parameter int OFS_FRAC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         r_i,
  input  logic [PIX_W-1:0]         g_i,
  input  logic [PIX_W-1:0]         b_i,
  input  logic [TAPS*COEF_W-1:0]   coef_i,
  output logic [PIX_W-1:0]         res_o
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam int ALIGN  = MUL_FRAC - OFS_FRAC;
  localparam logic signed [ACC_W-1:0] PIX_TOP  = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] OVER_LIM = ACC_W'(1 << (PIX_W + MUL_FRAC));

  // unsigned pixel times signed coefficient
  function automatic logic signed [PROD_W-1:0] mul_tap(
    input logic [PIX_W-1:0] px, input logic [COEF_W-1:0] c);
    logic signed [PROD_W-1:0] a;
    logic signed [PROD_W-1:0] b;
    a = PROD_W'($signed({1'b0, px}));
    b = PROD_W'($signed(c));
    return a * b;
  endfunction

  // floor to integer, then limit to the pixel range
  function automatic logic [PIX_W-1:0] sat_pix(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] whole;
    whole = acc >>> MUL_FRAC;
    if (whole < 0)            return '0;
    else if (whole > PIX_TOP) return '1;
    else                      return whole[PIX_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] prod_r_q, prod_g_q, prod_b_q;
  logic signed [COEF_W-1:0] const_q;
  logic signed [ACC_W-1:0]  acc;
  logic                     acc_neg;
  logic                     acc_over;

  // stage 1: products and constant captured with the pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_r_q <= '0;
      prod_g_q <= '0;
      prod_b_q <= '0;
      const_q  <= '0;
    end else begin
      prod_r_q <= mul_tap(r_i, coef_i[csc_pkg::TAP_RED   * COEF_W +: COEF_W]);
      prod_g_q <= mul_tap(g_i, coef_i[csc_pkg::TAP_GREEN * COEF_W +: COEF_W]);
      prod_b_q <= mul_tap(b_i, coef_i[csc_pkg::TAP_BLUE  * COEF_W +: COEF_W]);
      const_q  <= $signed(coef_i[csc_pkg::TAP_CONST * COEF_W +: COEF_W]);
    end
  end

  // stage 2: sum, align constant, saturate
  always_comb begin
    acc = ACC_W'(prod_r_q) + ACC_W'(prod_g_q) + ACC_W'(prod_b_q)
        + (ACC_W'(const_q) <<< ALIGN);
  end
  assign acc_neg  = acc < 0;
  assign acc_over = acc >= OVER_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_o <= '0;
    else        res_o <= sat_pix(acc);
  end

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_neg |=> res_o == '0); // R4
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_over |=> res_o == '1); // R4
endmodule

// File: rtl/pix_matrix_csc.sv
`timescale 1ns/1ps
module pix_matrix_csc #(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 14,
  parameter int MUL_FRAC = 10,
  parameter int OFS_FRAC = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3*PIX_W-1:0]   in_rgb,
  output logic                 out_valid,
  output logic [3*PIX_W-1:0]   out_yuv,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [COEF_W-1:0]    cfg_wdata
);
  localparam int ROWS    = csc_pkg::CSC_ROWS;
  localparam int TAPS    = csc_pkg::CSC_TAPS;
  localparam int LANES_W = ROWS * PIX_W;
  localparam int ROW_CW  = TAPS * COEF_W;

  logic [ROWS*ROW_CW-1:0] coef_flat;
  logic                   conv_en;

  csc_coef_bank #(
    .ROWS(ROWS), .TAPS(TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .coef_o(coef_flat), .conv_en_o(conv_en)
  );

  logic               v_s1, v_s2;
  logic               byp_s1, byp_s2;
  logic [LANES_W-1:0] raw_s1, raw_s2;
  logic [LANES_W-1:0] conv_lanes;
  logic [1:0]         warm;

  // side pipe: valid, mode and raw pixel follow the arithmetic two stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_s1   <= 1'b0;
      v_s2   <= 1'b0;
      byp_s1 <= 1'b0;
      byp_s2 <= 1'b0;
      raw_s1 <= '0;
      raw_s2 <= '0;
      warm   <= '0;
    end else begin
      v_s1   <= in_valid;
      v_s2   <= v_s1;
      byp_s1 <= !conv_en;
      byp_s2 <= byp_s1;
      raw_s1 <= in_rgb;
      raw_s2 <= raw_s1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  genvar gk;
  for (gk = 0; gk < ROWS; gk++) begin : g_row
    csc_row #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .TAPS(TAPS),
      .MUL_FRAC(MUL_FRAC), .OFS_FRAC(OFS_FRAC)
    ) u_row (
      .clk(clk), .rst_n(rst_n),
      .r_i(in_rgb[LANES_W-1 -: PIX_W]),
      .g_i(in_rgb[LANES_W-PIX_W-1 -: PIX_W]),
      .b_i(in_rgb[PIX_W-1:0]),
      .coef_i(coef_flat[gk*ROW_CW +: ROW_CW]),
      .res_o(conv_lanes[(ROWS-1-gk)*PIX_W +: PIX_W])
    );
  end

  assign out_valid = v_s2;
  assign out_yuv   = byp_s2 ? raw_s2 : conv_lanes;

  AST_VALID_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R5
  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm >= 2'd2) && out_valid && byp_s2) |-> (out_yuv == $past(in_rgb, 2))); // R2
endmodule

// File: tb/sim_pix_matrix_csc.sv
`timescale 1ns/1ps
module sim_pix_matrix_csc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_rgb = '0;
  logic        out_valid;
  logic [23:0] out_yuv;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [13:0] cfg_wdata = '0;

  always #2.5 clk = ~clk;

  pix_matrix_csc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rgb(in_rgb),
    .out_valid(out_valid), .out_yuv(out_yuv),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit live = 0;
  int mc[12] = '{263, 516, 100, 264, -151, -298, 449, 2056, 449, -376, -72, 2056};
  bit men = 0;
  logic [23:0] exp_q[$];
  int          stamp_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sx14(int v);
    return (v >= 8192) ? v - 16384 : v;
  endfunction

  // scaled to 14 fraction bits so products and constant share one divisor
  function automatic int lane(int r, int g, int b, int idx);
    int tot;
    tot = 16 * (r * mc[idx] + g * mc[idx+1] + b * mc[idx+2]) + 1024 * mc[idx+3];
    if (tot < 0) return 0;
    tot = tot / 16384;
    return (tot > 255) ? 255 : tot;
  endfunction

  function automatic logic [23:0] model(logic [23:0] p);
    int r, g, b;
    if (!men) return p;
    r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]);
    return {8'(lane(r, g, b, 0)), 8'(lane(r, g, b, 4)), 8'(lane(r, g, b, 8))};
  endfunction

  task automatic step(bit v, logic [23:0] p, bit we, logic [3:0] a, logic [13:0] d, string tag);
    @(negedge clk);
    in_valid = v; in_rgb = p; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    if (v) begin
      exp_q.push_back(model(p));
      stamp_q.push_back(cyc);
      tag_q.push_back(tag);
    end
    // the write lands at the same edge that accepts this pixel
    if (we) begin
      if (a < 4'd12) mc[a] = sx14(int'(d));
      else if (a == 4'd12) men = d[0];
    end
  endtask

  task automatic px(logic [23:0] p, string tag);
    step(1'b1, p, 1'b0, 4'd0, 14'd0, tag);
  endtask

  // output checker: one check per cycle (R5 timing plus lane values)
  always @(negedge clk) begin
    if (live) begin
      bit due;
      due = (stamp_q.size() > 0) && (stamp_q[0] + 2 == cyc);
      checks++;
      if (due) begin
        if (!out_valid || out_yuv !== exp_q[0]) begin
          failures++;
          $display("FAIL %s cyc=%0d actual valid=%0b data=%06h expected valid=1 data=%06h",
                   tag_q[0], cyc, out_valid, out_yuv, exp_q[0]);
        end
        void'(exp_q.pop_front()); void'(stamp_q.pop_front()); void'(tag_q.pop_front());
      end else if (out_valid !== 1'b0) begin
        failures++;
        $display("FAIL R5 cyc=%0d actual valid=%0b expected valid=0", cyc, out_valid);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 1'b0 || out_yuv !== 24'h0) begin
      failures++;
      $display("FAIL R1 actual valid=%0b data=%06h expected valid=0 data=000000", out_valid, out_yuv);
    end
    live = 1;

    // R1 / R2: conversion off after reset, pixels pass untouched
    for (int i = 0; i < 256; i++) px({8'(i), 8'(255 - i), 8'((i * 7) & 255)}, "R2");

    // R8: enable written together with a pixel; that pixel still passes through
    step(1'b1, 24'h123456, 1'b1, 4'd12, 14'd1, "R8");

    // R1: reset matrix on black, white and pure primaries
    px(24'h000000, "R1"); px(24'hFFFFFF, "R1"); px(24'hFF0000, "R1");
    px(24'h00FF00, "R1"); px(24'h0000FF, "R1");

    // R3: near-exhaustive grid under the reset matrix
    for (int r = 0; r < 256; r += 17)
      for (int g = 0; g < 256; g += 17)
        for (int b = 0; b < 256; b += 17)
          px({8'(r), 8'(g), 8'(b)}, "R3");

    // R8 / R6: load a matrix in index order with a pixel in every write cycle
    begin
      logic [13:0] sat_set[12] = '{14'h0400, 14'h0400, 14'h0400, 14'h0000,
                                   14'h3C00, 14'h3C00, 14'h3C00, 14'h0000,
                                   14'h0400, 14'h3C00, 14'h0000, 14'h0808};
      for (int i = 0; i < 12; i++)
        step(1'b1, {8'((i * 37) & 255), 8'((i * 91) & 255), 8'((i * 13 + 200) & 255)},
             1'b1, 4'(i), sat_set[i], "R8");
    end

    // R4: saturation at both ends
    for (int r = 0; r < 256; r += 51)
      for (int g = 0; g < 256; g += 51)
        for (int b = 0; b < 256; b += 51)
          px({8'(r), 8'(g), 8'(b)}, "R4");

    // R6: single entries change only their own row and tap
    step(1'b1, 24'h80A0C0, 1'b1, 4'd10, 14'h0000, "R6");
    step(1'b1, 24'h4080FF, 1'b1, 4'd3, 14'h0100, "R6");
    step(1'b1, 24'h102030, 1'b1, 4'd5, 14'h0200, "R6");
    for (int r = 0; r < 256; r += 127)
      for (int g = 0; g < 256; g += 127)
        for (int b = 0; b < 256; b += 127)
          px({8'(r), 8'(g), 8'(b)}, "R6");

    // R7: writes beyond the enable address are dropped
    step(1'b1, 24'h55AA33, 1'b1, 4'd13, 14'h3FFF, "R7");
    step(1'b1, 24'hAA5533, 1'b1, 4'd14, 14'h3FFE, "R7");
    step(1'b1, 24'h33AA55, 1'b1, 4'd15, 14'h3FFF, "R7");
    for (int r = 0; r < 256; r += 127)
      for (int g = 0; g < 256; g += 127)
        for (int b = 0; b < 256; b += 127)
          px({8'(r), 8'(g), 8'(b)}, "R7");

    // R5: gaps in the input stream
    for (int i = 0; i < 60; i++)
      step(i % 3 != 0, {8'(i * 4), 8'(255 - i), 8'(i * 3)}, 1'b0, 4'd0, 14'd0, "R5");

    // R8: disable written with a pixel, that pixel is still converted
    step(1'b1, 24'hC08040, 1'b1, 4'd12, 14'd0, "R8");
    for (int i = 0; i < 20; i++) px({8'(i * 11), 8'(i * 5), 8'(255 - i * 9)}, "R2");

    for (int i = 0; i < 5; i++) step(1'b0, 24'h0, 1'b0, 4'd0, 14'd0, "R5");
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R5 actual pending=%0d expected pending=0", exp_q.size());
    end
    finish_run();
  end
endmodule